// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block carries out the stack side of subroutine and register-pair instructions for a small 8-bit processor that has a 16-bit stack pointer and a byte-wide memory port. A decoder raises a start strobe together with an operation code, the current PC, SP and register pair, a call target, a restart index and a condition result. The sequencer then walks through a fixed series of machine cycles. In those cycles it moves SP one byte at a time, drives byte writes or reads at the current SP, and puts together the new PC or the popped word.

Every operation has a fixed length, and a conditional call or return takes a different number of cycles when it is taken than when it is not. A single-cycle done strobe marks the last cycle of every operation. The caller reads the resulting SP, PC, popped word and interrupt-enable request in that cycle. While an operation is in progress the sequencer ignores any new start. Deciding whether a condition holds and fetching instructions are left to the caller.

Top module: `stack_seq`

## Requirements
- R1: After reset, done, mem_we, mem_re and ime_set are low, and sp_out and pc_out are 0.
- R2: Push word (op 0) lasts 4 cycles. In cycle 2 it writes the high byte at SP-1, and in cycle 4 it writes the low byte at SP-2. SP ends at SP-2. Cycle k is the k-th clock cycle after the edge that accepts start, and done is high in the last cycle.
- R3: Push flags (op 1) writes the low byte with bits 3..0 forced to zero. Pop flags (op 3) returns the low byte with bits 3..0 cleared.
- R4: Pop word (op 2) lasts 3 cycles. It reads the low byte at SP, then the high byte at SP+1. It returns the word on pop_data and leaves SP at SP+2. Each read moves SP up by one in the next cycle.
- R5: Call (op 4, and op 5 with cond_ok=1) lasts 6 cycles. It pushes PC+3, with the high byte written in cycle 4 and the low byte in cycle 6. It then sets pc_out to target. Op 4 ignores cond_ok.
- R6: A conditional call that is not taken (op 5, cond_ok=0) lasts 3 cycles. It makes no memory access, leaves SP unchanged and gives pc_out = PC+3.
- R7: Return (op 6) lasts 4 cycles. It pops the new PC, low byte first, and leaves SP at SP+2.
- R8: A conditional return (op 7) lasts 5 cycles when taken. When not taken it lasts 2 cycles, reads nothing, leaves SP unchanged and gives pc_out = PC+1.
- R9: Restart call (op 8) lasts 4 cycles. It pushes PC+1 and sets pc_out to vec_idx*8, which is one of 0x00 to 0x38.
- R10: Return-from-interrupt (op 9) behaves like a return, and raises ime_set in its done cycle only.
- R11: done is high for exactly one cycle per operation. A start while the sequencer is busy has no effect. Op codes 10 to 15 start nothing.
- R12: SP arithmetic wraps modulo 2^16 for both decrement and increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, sampled when idle |
| op | input | 4 | Operation code (0..9) |
| cond_ok | input | 1 | Condition result for ops 5 and 7 |
| target | input | 16 | Call destination |
| pc_in | input | 16 | Address of the current instruction |
| sp_in | input | 16 | Stack pointer at start |
| pair_in | input | 16 | Register pair to push |
| vec_idx | input | 3 | Restart vector index |
| mem_rdata | input | 8 | Read data for mem_addr, same cycle |
| mem_addr | output | 16 | Byte address (current SP) |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| sp_out | output | 16 | Current stack pointer |
| pc_out | output | 16 | New PC, valid with done |
| pop_data | output | 16 | Popped word, valid with done |
| ime_set | output | 1 | Interrupt enable request |
| done | output | 1 | Last cycle of an operation |

## Verification
The bench builds the block with its defaults: 8-bit bytes, which give a 16-bit SP and PC, a call length of 3, a restart and return length of 1, and a vector spacing of 8. With those values a push at SP 0x0000 and a pop at SP 0xFFFF cross the 16-bit wrap, and restart indices 5 and 7 reach vectors 0x28 and 0x38. With the 16-bit return addresses, the high-byte and low-byte order can be told apart at fixed cycle numbers.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int DW       = 8,
  parameter int CALL_LEN = 3,
  parameter int RST_LEN  = 1,
  parameter int RET_LEN  = 1,
  parameter int VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic              cond_ok,
  input  logic [2*DW-1:0]   target,
  input  logic [2*DW-1:0]   pc_in,
  input  logic [2*DW-1:0]   sp_in,
  input  logic [2*DW-1:0]   pair_in,
  input  logic [2:0]        vec_idx,
  input  logic [DW-1:0]     mem_rdata,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [2*DW-1:0]   sp_out,
  output logic [2*DW-1:0]   pc_out,
  output logic [2*DW-1:0]   pop_data,
  output logic              ime_set,
  output logic              done
);
  localparam int AW = 2*DW;
  localparam logic [DW-1:0] FMASK = {{4{1'b1}}, {(DW-4){1'b0}}};
  localparam logic [3:0] OP_PUSH = 4'd0, OP_PUSHF = 4'd1, OP_POP = 4'd2, OP_POPF = 4'd3,
                         OP_CALL = 4'd4, OP_CALLC = 4'd5, OP_RET = 4'd6, OP_RETC = 4'd7,
                         OP_RST  = 4'd8, OP_RETI  = 4'd9;

  logic          busy;
  logic [2:0]    step;
  logic [3:0]    op_r;
  logic          taken_r;
  logic [AW-1:0] sp_r, word_r, pcn_r, pop_r;

  logic          taken_s;
  logic [AW-1:0] word_s, pcn_s;

  always_comb begin
    taken_s = (op == OP_CALLC || op == OP_RETC) ? cond_ok : 1'b1;
    case (op)
      OP_PUSHF:         word_s = {pair_in[AW-1:DW], pair_in[DW-1:0] & FMASK};
      OP_CALL, OP_CALLC: word_s = pc_in + AW'(CALL_LEN);
      OP_RST:           word_s = pc_in + AW'(RST_LEN);
      default:          word_s = pair_in;
    endcase
    case (op)
      OP_CALL:  pcn_s = target;
      OP_CALLC: pcn_s = cond_ok ? target : pc_in + AW'(CALL_LEN);
      OP_RST:   pcn_s = AW'(vec_idx) * AW'(VEC_STEP);
      OP_RETC:  pcn_s = pc_in + AW'(RET_LEN);
      default:  pcn_s = pc_in;
    endcase
  end

  logic       is_push, is_pop, ret_taken;
  logic [2:0] base, n_len;

  always_comb begin
    is_push = 1'b0;
    is_pop  = 1'b0;
    base    = 3'd1;
    n_len   = 3'd1;
    case (op_r)
      OP_PUSH, OP_PUSHF, OP_RST: begin is_push = 1'b1; n_len = 3'd4; end
      OP_POP, OP_POPF:           begin is_pop  = 1'b1; n_len = 3'd3; end
      OP_CALL, OP_CALLC: begin
        is_push = taken_r;
        base    = 3'd3;
        n_len   = taken_r ? 3'd6 : 3'd3;
      end
      OP_RET, OP_RETI:           begin is_pop  = 1'b1; n_len = 3'd4; end
      OP_RETC: begin
        is_pop = taken_r;
        base   = 3'd2;
        n_len  = taken_r ? 3'd5 : 3'd2;
      end
      default: ;
    endcase
  end

  wire [2:0] rel    = step - base;
  wire       in_win = busy && (step >= base);
  wire       sp_dec = in_win && is_push && (rel == 3'd0 || rel == 3'd2);
  wire       wr_hi  = in_win && is_push && rel == 3'd1;
  wire       wr_lo  = in_win && is_push && rel == 3'd3;
  wire       rd_lo  = in_win && is_pop  && rel == 3'd0;
  wire       rd_hi  = in_win && is_pop  && rel == 3'd1;

  assign ret_taken = (op_r == OP_RET) || (op_r == OP_RETI) || (op_r == OP_RETC && taken_r);

  assign mem_addr  = sp_r;
  assign mem_we    = wr_hi || wr_lo;
  assign mem_re    = rd_lo || rd_hi;
  assign mem_wdata = wr_hi ? word_r[AW-1:DW] : word_r[DW-1:0];
  assign done      = busy && (step == n_len);
  assign ime_set   = done && (op_r == OP_RETI);
  assign sp_out    = sp_r;
  assign pop_data  = pop_r;
  assign pc_out    = ret_taken ? pop_r : pcn_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      step    <= 3'd0;
      op_r    <= OP_PUSH;
      taken_r <= 1'b0;
      sp_r    <= '0;
      word_r  <= '0;
      pcn_r   <= '0;
      pop_r   <= '0;
    end else if (!busy) begin
      if (start && op <= OP_RETI) begin
        busy    <= 1'b1;
        step    <= 3'd1;
        op_r    <= op;
        taken_r <= taken_s;
        sp_r    <= sp_in;
        word_r  <= word_s;
        pcn_r   <= pcn_s;
      end
    end else begin
      if (done) busy <= 1'b0;
      else      step <= step + 3'd1;
      if (sp_dec)              sp_r <= sp_r - 1'b1;
      else if (rd_lo || rd_hi) sp_r <= sp_r + 1'b1;
      if (rd_lo) pop_r[DW-1:0]  <= (op_r == OP_POPF) ? (mem_rdata & FMASK) : mem_rdata;
      if (rd_hi) pop_r[AW-1:DW] <= mem_rdata;
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_holds_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(op_r) && busy);
  assert_read_advances_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp_out == $past(sp_out) + 1'b1));
  assert_writes_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  assert_no_rw_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;
  logic clk = 0, rst_n = 0, start = 0, cond_ok = 0;
  logic [3:0] op = 0;
  logic [15:0] target = 0, pc_in = 0, sp_in = 0, pair_in = 0;
  logic [2:0] vec_idx = 0;
  logic [7:0] mem_rdata, mem_wdata;
  logic [15:0] mem_addr, sp_out, pc_out, pop_data;
  logic mem_we, mem_re, ime_set, done;

  stack_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_ok(cond_ok),
    .target(target), .pc_in(pc_in), .sp_in(sp_in), .pair_in(pair_in), .vec_idx(vec_idx),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .sp_out(sp_out), .pc_out(pc_out), .pop_data(pop_data),
    .ime_set(ime_set), .done(done));

  always #2.5 clk = ~clk;

  logic [7:0] bmem [256];
  assign mem_rdata = bmem[mem_addr[7:0]];

  int checks = 0, failures = 0;
  int cyc, nwr, nrd, ndone, ime_cnt, ime_bad;
  logic [15:0] wr_a [8];
  logic [7:0]  wr_d [8];
  int          wr_k [8];
  logic [15:0] sp_f, pc_f, pop_f;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic c, input logic [15:0] tgt,
                        input logic [15:0] pc, input logic [15:0] sp, input logic [15:0] pr,
                        input logic [2:0] vi, input bit poke);
    @(negedge clk);
    op = o; cond_ok = c; target = tgt; pc_in = pc; sp_in = sp; pair_in = pr; vec_idx = vi;
    start = 1;
    @(posedge clk); #1 start = 0;
    cyc = 0; nwr = 0; nrd = 0; ndone = 0; ime_cnt = 0; ime_bad = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (poke && k == 2) begin start = 1; op = 4'd2; sp_in = 16'h0200; end
      if (poke && k == 3) start = 0;
      if (mem_we) begin
        if (nwr < 8) begin wr_a[nwr] = mem_addr; wr_d[nwr] = mem_wdata; wr_k[nwr] = k; end
        nwr++;
        bmem[mem_addr[7:0]] = mem_wdata;
      end
      if (mem_re) nrd++;
      if (ime_set) begin if (done) ime_cnt++; else ime_bad++; end
      if (done) begin
        ndone++;
        if (cyc == 0) begin cyc = k; sp_f = sp_out; pc_f = pc_out; pop_f = pop_data; end
      end
      if (cyc != 0 && k > cyc) break;
    end
    start = 0;
  endtask

  task automatic t_reset;
    chk(done == 0 && mem_we == 0 && mem_re == 0 && ime_set == 0, "R1", "ctrl low",
        {done, mem_we, mem_re, ime_set}, 0);
    chk(sp_out == 0 && pc_out == 0, "R1", "sp/pc zero", {sp_out, pc_out}, 0);
  endtask

  task automatic t_push;
    run_op(4'd0, 0, 0, 0, 16'hC010, 16'hBEEF, 0, 0);
    chk(cyc == 4, "R2", "push cycles", cyc, 4);
    chk(nwr == 2 && wr_k[0] == 2 && wr_a[0] == 16'hC00F && wr_d[0] == 8'hBE, "R2", "push high byte",
        {wr_a[0], wr_d[0]}, {16'hC00F, 8'hBE});
    chk(wr_k[1] == 4 && wr_a[1] == 16'hC00E && wr_d[1] == 8'hEF, "R2", "push low byte",
        {wr_a[1], wr_d[1]}, {16'hC00E, 8'hEF});
    chk(sp_f == 16'hC00E, "R2", "push sp", sp_f, 16'hC00E);
    chk(ndone == 1, "R11", "push done width", ndone, 1);
  endtask

  task automatic t_flags;
    run_op(4'd1, 0, 0, 0, 16'h0040, 16'h12F5, 0, 0);
    chk(nwr == 2 && wr_d[0] == 8'h12 && wr_d[1] == 8'hF0, "R3", "push flags bytes",
        {wr_d[0], wr_d[1]}, 16'h12F0);
    bmem[8'h20] = 8'h3B; bmem[8'h21] = 8'h77;
    run_op(4'd3, 0, 0, 0, 16'h0020, 0, 0, 0);
    chk(pop_f == 16'h7730, "R3", "pop flags word", pop_f, 16'h7730);
  endtask

  task automatic t_pop;
    run_op(4'd2, 0, 0, 0, 16'hC00E, 0, 0, 0);
    chk(cyc == 3, "R4", "pop cycles", cyc, 3);
    chk(pop_f == 16'hBEEF, "R4", "pop word", pop_f, 16'hBEEF);
    chk(sp_f == 16'hC010 && nrd == 2 && nwr == 0, "R4", "pop sp", sp_f, 16'hC010);
  endtask

  task automatic t_call;
    run_op(4'd4, 0, 16'h4000, 16'h1234, 16'hD000, 0, 0, 0);
    chk(cyc == 6, "R5", "call cycles", cyc, 6);
    chk(nwr == 2 && wr_k[0] == 4 && wr_a[0] == 16'hCFFF && wr_d[0] == 8'h12, "R5", "call high",
        {wr_a[0], wr_d[0]}, {16'hCFFF, 8'h12});
    chk(wr_k[1] == 6 && wr_a[1] == 16'hCFFE && wr_d[1] == 8'h37, "R5", "call low",
        {wr_a[1], wr_d[1]}, {16'hCFFE, 8'h37});
    chk(pc_f == 16'h4000 && sp_f == 16'hCFFE, "R5", "call pc/sp", {pc_f, sp_f}, {16'h4000, 16'hCFFE});
    run_op(4'd5, 1, 16'h5000, 16'h1234, 16'hD000, 0, 0, 0);
    chk(cyc == 6 && pc_f == 16'h5000 && nwr == 2, "R5", "cond call taken", pc_f, 16'h5000);
  endtask

  task automatic t_call_nt;
    run_op(4'd5, 0, 16'h5000, 16'h1234, 16'hD000, 0, 0, 0);
    chk(cyc == 3, "R6", "not-taken call cycles", cyc, 3);
    chk(nwr == 0 && nrd == 0 && sp_f == 16'hD000, "R6", "no access", {nwr[7:0], sp_f}, {8'h0, 16'hD000});
    chk(pc_f == 16'h1237, "R6", "fall-through pc", pc_f, 16'h1237);
  endtask

  task automatic t_ret;
    run_op(4'd6, 0, 0, 16'h4100, 16'hCFFE, 0, 0, 0);
    chk(cyc == 4, "R7", "ret cycles", cyc, 4);
    chk(pc_f == 16'h1237 && sp_f == 16'hD000 && ime_cnt == 0, "R7", "ret pc/sp",
        {pc_f, sp_f}, {16'h1237, 16'hD000});
    run_op(4'd7, 1, 0, 16'h4100, 16'hCFFE, 0, 0, 0);
    chk(cyc == 5 && pc_f == 16'h1237 && sp_f == 16'hD000, "R8", "cond ret taken", cyc, 5);
    run_op(4'd7, 0, 0, 16'h2000, 16'hCFFE, 0, 0, 0);
    chk(cyc == 2, "R8", "cond ret not taken cycles", cyc, 2);
    chk(pc_f == 16'h2001 && nrd == 0 && sp_f == 16'hCFFE, "R8", "cond ret not taken pc",
        pc_f, 16'h2001);
  endtask

  task automatic t_rst_reti;
    run_op(4'd8, 0, 16'h9999, 16'h0150, 16'hFFFE, 0, 3'd5, 0);
    chk(cyc == 4 && pc_f == 16'h0028, "R9", "restart 5", pc_f, 16'h0028);
    chk(nwr == 2 && wr_a[0] == 16'hFFFD && wr_d[0] == 8'h01 && wr_a[1] == 16'hFFFC && wr_d[1] == 8'h51,
        "R9", "restart return addr", {wr_d[0], wr_d[1]}, 16'h0151);
    run_op(4'd9, 0, 0, 16'h0028, 16'hFFFC, 0, 0, 0);
    chk(cyc == 4 && pc_f == 16'h0151 && sp_f == 16'hFFFE, "R10", "reti pc", pc_f, 16'h0151);
    chk(ime_cnt == 1 && ime_bad == 0, "R10", "ime only in done", {ime_cnt[7:0], ime_bad[7:0]}, 16'h0100);
    run_op(4'd8, 0, 0, 16'h0000, 16'h0100, 0, 3'd7, 0);
    chk(pc_f == 16'h0038, "R9", "restart 7", pc_f, 16'h0038);
  endtask

  task automatic t_wrap;
    run_op(4'd0, 0, 0, 0, 16'h0000, 16'hA55A, 0, 0);
    chk(wr_a[0] == 16'hFFFF && wr_a[1] == 16'hFFFE && sp_f == 16'hFFFE, "R12", "push wrap",
        {wr_a[0], sp_f}, {16'hFFFF, 16'hFFFE});
    bmem[8'h00] = 8'h3C;
    run_op(4'd2, 0, 0, 0, 16'hFFFF, 0, 0, 0);
    chk(pop_f == 16'h3CA5 && sp_f == 16'h0001, "R12", "pop wrap", {pop_f, sp_f}, {16'h3CA5, 16'h0001});
  endtask

  task automatic t_busy;
    int extra;
    run_op(4'd0, 0, 0, 0, 16'h0100, 16'h1111, 0, 1);
    chk(cyc == 4 && sp_f == 16'h00FE && ndone == 1, "R11", "start while busy", sp_f, 16'h00FE);
    extra = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (done || mem_re) extra++; end
    chk(extra == 0, "R11", "no queued op", extra, 0);
    @(negedge clk); op = 4'd12; start = 1; @(negedge clk); start = 0;
    extra = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (done || mem_we || mem_re) extra++; end
    chk(extra == 0, "R11", "unknown op ignored", extra, 0);
  endtask

  initial begin
    #1000000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_push;
    t_flags;
    t_pop;
    t_call;
    t_call_nt;
    t_ret;
    t_rst_reti;
    t_wrap;
    t_busy;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule